// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a synchronous serial slave that gives a host read and write access to a small bank of configuration registers. Every access cycle opens with an instruction byte. That byte carries a read/write flag and a five-bit register address. It is followed by as many data bytes as the addressed register is wide. The serial clock, chip select and data input are sampled in the system clock domain, so the whole port runs on one clock.

Written bytes land in holding buffers and do not reach the active register outputs until a commit. A commit happens when the update input is high at a rising edge of an internal sync clock, which runs at a quarter of the system clock. Reads always return the active (committed) contents.

Two mode bits live in the lowest byte of register 0. One selects the bit and byte order. The other routes read data to a dedicated output pin instead of the shared data pin. Both bits act as soon as that byte has been shifted in. An active-high port reset abandons any transfer in progress.

Top module: `serreg_port`

## Requirements
- R1: The first 8 rising serial clock edges after reset, after a port reset, or after a completed cycle form the instruction byte. In that byte, bit 7 = 1 means read and 0 means write, bits 6:5 are ignored, and bits 4:0 are the register address.
- R2: Each register has a fixed data byte count: address 0:4, 1:3, 2:2, 3:4, 4:4, 5:2, 6:1, 7:4. After that many data bytes the cycle ends. Written bits above the register's byte count stay zero.
- R3: Input bits are captured on rising serial clock edges. Read bits change only after falling edges, so each read bit is stable for the whole high phase that follows.
- R4: In MSB-first mode (the reset mode), each byte is sent bit 7 first and the bytes of a register go from the most significant down. In LSB-first mode, each byte is sent bit 0 first and the bytes go from byte 0 upward. The instruction byte also follows the current bit order.
- R5: Register 0 byte 0 bit 0 selects LSB-first order (1) and bit 1 selects the separate output pin (1). Both take effect as soon as that byte is received, and they apply to the remaining bytes of the same cycle. The byte sequence of a cycle is fixed when its instruction is decoded.
- R6: A write changes only the holding buffer. `regs_out` and read-back keep their old value until a commit.
- R7: `sync_clk` is the system clock divided by 4 (two cycles high, two low). When `update` is high at a rising edge of `sync_clk`, all holding buffers are copied to `regs_out`.
- R8: `port_rst` aborts the current transfer at once and discards any partially shifted byte. The next rising edges form a new instruction byte.
- R9: While `cs_n` is high, serial clock edges are ignored and both output enables are low.
- R10: In single-pin mode, read data appears on `sdio_out` with `sdio_oe` high and `sdo_oe` low. In separate-pin mode it appears on `sdo` with `sdo_oe` high and `sdio_oe` low. Input is always taken from `sdio_in`.
- R11: Addresses 8 to 31 take exactly one data byte. Writing to them has no effect, and reading them returns zero.
- R12: `rst` clears all holding buffers, `regs_out`, both mode bits and `sync_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_rst | input | 1 | Asynchronous active-high abort of the serial transfer |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data in |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo | output | 1 | Read data for the separate output pin |
| sdo_oe | output | 1 | Drive enable for the separate output pin |
| update | input | 1 | Commit request, sampled on rising edges of sync_clk |
| sync_clk | output | 1 | System clock divided by 4 |
| regs_out | output | 256 | Active registers, register n at bits n*32 +: 32 |

## Verification
The assertions assume the following about the inputs:
- `cs_n` and `update` change only between system clock edges.
- The serial clock holds each level for several system clocks, so every edge is seen once by the sampler.
- Data input changes only while the serial clock is low.

The bench drives every input on the falling system clock edge and holds each serial clock phase for five system clocks. It changes data only together with the falling serial edge. It holds `update` for four system clocks, which covers exactly one sync clock rising edge.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int ADDR_W    = 5;
    localparam int NREG      = 8;
    localparam int REG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int REG_BYTES = REG_W / BYTE_W;
    localparam int IDX_W     = $clog2(NREG);
    localparam int LANE_W    = $clog2(REG_BYTES);
    localparam int CNT_W     = $clog2(REG_BYTES + 1);
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int REGS_W    = NREG * REG_W;
    localparam int DIV_W     = 2;

    typedef enum logic {
        PH_INSTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        spare;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic              rd;
        logic              asc;
        logic [ADDR_W-1:0] addr;
        logic [LANE_W-1:0] lane;
        logic [CNT_W-1:0]  left;
    } xfer_t;

    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic din;
    } pins_t;

    // Data byte count per address; zero marks an undefined address.
    function automatic logic [CNT_W-1:0] reg_nbytes(input logic [ADDR_W-1:0] a);
        logic [CNT_W-1:0] n;
        case (a)
            5'd0:    n = 3'd4;
            5'd1:    n = 3'd3;
            5'd2:    n = 3'd2;
            5'd3:    n = 3'd4;
            5'd4:    n = 3'd4;
            5'd5:    n = 3'd2;
            5'd6:    n = 3'd1;
            5'd7:    n = 3'd4;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sr,
                                                   input logic din,
                                                   input logic lsb);
        return lsb ? {din, sr[BYTE_W-1:1]} : {sr[BYTE_W-2:0], din};
    endfunction

endpackage

// File: rtl/serreg_sampler.sv
module serreg_sampler
    import serreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic rise,
    output logic fall,
    output logic din_s
);

    pins_t s1;
    logic  sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= '{sclk: 1'b0, cs_n: 1'b1, din: 1'b0};
            sclk_d <= 1'b0;
        end else begin
            s1     <= '{sclk: sclk, cs_n: cs_n, din: din};
            sclk_d <= s1.sclk;
        end
    end

    assign rise  = !s1.cs_n &&  s1.sclk && !sclk_d;
    assign fall  = !s1.cs_n && !s1.sclk &&  sclk_d;
    assign din_s = s1.din;

endmodule

// File: rtl/serreg_engine.sv
module serreg_engine
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              port_rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              lsb_mode,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANE_W-1:0] cur_lane,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANE_W-1:0] wr_lane,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              reading,
    output logic              dout
);

    phase_e            phase;
    logic [BIT_W-1:0]  bitc;
    logic [BYTE_W-1:0] sr;
    xfer_t             xf;

    logic [BYTE_W-1:0] nsr;
    instr_t            ib;
    logic [CNT_W-1:0]  nb;
    logic [CNT_W-1:0]  nbc;
    logic              unused_spare;

    always_comb begin
        nsr          = shift_in(sr, din, lsb_mode);
        ib           = instr_t'(nsr);
        nb           = reg_nbytes(ib.addr);
        nbc          = (nb == '0) ? CNT_W'(1) : nb;
        unused_spare = ^ib.spare;
    end

    always_ff @(posedge clk or posedge port_rst) begin
        if (port_rst) begin
            phase   <= PH_INSTR;
            bitc    <= '0;
            sr      <= '0;
            xf      <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_lane <= '0;
            wr_byte <= '0;
            dout    <= 1'b0;
        end else if (rst) begin
            phase   <= PH_INSTR;
            bitc    <= '0;
            sr      <= '0;
            xf      <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_lane <= '0;
            wr_byte <= '0;
            dout    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (rise) begin
                if (bitc == BIT_W'(BYTE_W - 1)) begin
                    bitc <= '0;
                    sr   <= '0;
                    if (phase == PH_INSTR) begin
                        xf.rd   <= ib.rd;
                        xf.addr <= ib.addr;
                        xf.asc  <= lsb_mode;
                        xf.left <= nbc;
                        xf.lane <= lsb_mode ? '0 : LANE_W'(nbc - CNT_W'(1));
                        phase   <= PH_DATA;
                    end else begin
                        wr_en   <= !xf.rd && (reg_nbytes(xf.addr) != '0);
                        wr_addr <= xf.addr;
                        wr_lane <= xf.lane;
                        wr_byte <= nsr;
                        if (xf.left == CNT_W'(1)) begin
                            phase <= PH_INSTR;
                        end else begin
                            xf.left <= xf.left - CNT_W'(1);
                            xf.lane <= xf.asc ? xf.lane + LANE_W'(1)
                                              : xf.lane - LANE_W'(1);
                        end
                    end
                end else begin
                    bitc <= bitc + BIT_W'(1);
                    sr   <= nsr;
                end
            end
            if (fall && phase == PH_DATA && xf.rd) begin
                dout <= lsb_mode ? rd_byte[bitc] : rd_byte[BIT_W'(BYTE_W - 1) - bitc];
            end
        end
    end

    assign cur_addr = xf.addr;
    assign cur_lane = xf.lane;
    assign reading  = (phase == PH_DATA) && xf.rd;

endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic              update,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              lsb_mode,
    output logic              three_wire,
    output logic              sync_clk,
    output logic [REGS_W-1:0] regs_out
);

    logic [NREG-1:0][REG_W-1:0] shadow;
    logic [NREG-1:0][REG_W-1:0] active;
    logic [DIV_W-1:0]           div_q;
    logic                       commit;

    // Divide-by-4: sync_clk rises on the edge where div_q goes 1 -> 2.
    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + DIV_W'(1);
    end
    assign sync_clk = div_q[DIV_W-1];
    assign commit   = update && (div_q == DIV_W'(1));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    shadow[g][b*BYTE_W +: BYTE_W] <= '0;
                end else if (wr_en && wr_addr == ADDR_W'(g) && wr_lane == LANE_W'(b)) begin
                    shadow[g][b*BYTE_W +: BYTE_W] <= wr_byte;
                end
            end
        end
        always_ff @(posedge clk) begin
            if (rst)         active[g] <= '0;
            else if (commit) active[g] <= shadow[g];
        end
    end

    // Port mode bits act immediately, without waiting for a commit.
    always_ff @(posedge clk) begin
        if (rst) begin
            lsb_mode   <= 1'b0;
            three_wire <= 1'b0;
        end else if (wr_en && wr_addr == '0 && wr_lane == '0) begin
            lsb_mode   <= wr_byte[0];
            three_wire <= wr_byte[1];
        end
    end

    always_comb begin
        rd_byte = '0;
        if (rd_addr < ADDR_W'(NREG)) begin
            rd_byte = active[rd_addr[IDX_W-1:0]][{rd_lane, 3'b000} +: BYTE_W];
        end
    end

    assign regs_out = active;

endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              port_rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              update,
    output logic              sync_clk,
    output logic [REGS_W-1:0] regs_out
);

    logic              rise, fall, din_s;
    logic              lsb_mode, three_wire;
    logic [BYTE_W-1:0] rd_byte;
    logic [ADDR_W-1:0] cur_addr, wr_addr;
    logic [LANE_W-1:0] cur_lane, wr_lane;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte;
    logic              reading, dout;

    serreg_sampler u_samp (
        .clk   (clk),
        .rst   (rst),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .din   (sdio_in),
        .rise  (rise),
        .fall  (fall),
        .din_s (din_s)
    );

    serreg_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .port_rst (port_rst),
        .rise     (rise),
        .fall     (fall),
        .din      (din_s),
        .lsb_mode (lsb_mode),
        .rd_byte  (rd_byte),
        .cur_addr (cur_addr),
        .cur_lane (cur_lane),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_lane  (wr_lane),
        .wr_byte  (wr_byte),
        .reading  (reading),
        .dout     (dout)
    );

    serreg_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_lane    (wr_lane),
        .wr_byte    (wr_byte),
        .rd_addr    (cur_addr),
        .rd_lane    (cur_lane),
        .update     (update),
        .rd_byte    (rd_byte),
        .lsb_mode   (lsb_mode),
        .three_wire (three_wire),
        .sync_clk   (sync_clk),
        .regs_out   (regs_out)
    );

    assign sdio_out = dout;
    assign sdo      = dout;
    assign sdio_oe  = !cs_n && reading && !three_wire;
    assign sdo_oe   = !cs_n && reading &&  three_wire;

endmodule

// File: rtl/serreg_port_chk.sv
module serreg_port_chk
    import serreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sdio_oe,
    input logic              sdo_oe,
    input logic              update,
    input logic              sync_clk,
    input logic [REGS_W-1:0] regs_out
);

    p_oe_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sdio_oe && !sdo_oe));

    p_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(sdio_oe && sdo_oe));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !($rose(sync_clk) && $past(update)) |-> $stable(regs_out));

    p_div_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_clk) |=> $stable(sync_clk));

    p_div_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_clk) |=> $stable(sync_clk));

endmodule

bind serreg_port serreg_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sdio_oe  (sdio_oe),
    .sdo_oe   (sdo_oe),
    .update   (update),
    .sync_clk (sync_clk),
    .regs_out (regs_out)
);

// File: tb/tb_serreg_port.sv
module tb_serreg_port;

    localparam int H = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         port_rst = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdio_in = 1'b0;
    logic         update = 1'b0;
    logic         sdio_out, sdio_oe, sdo, sdo_oe, sync_clk;
    logic [255:0] regs_out;

    int   n_chk = 0;
    int   n_fail = 0;
    int   glitch = 0;
    int   oe_bad = 0;
    logic in_rd = 1'b0;
    logic m_lsb = 1'b0;
    logic m_3w = 1'b0;

    serreg_port dut (
        .clk(clk), .rst(rst), .port_rst(port_rst), .sclk(sclk), .cs_n(cs_n),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .sdo_oe(sdo_oe), .update(update), .sync_clk(sync_clk), .regs_out(regs_out)
    );

    always #5 clk = ~clk;

    function automatic int exp_n(input int a);
        case (a)
            0: return 4; 1: return 3; 2: return 2; 3: return 4;
            4: return 4; 5: return 2; 6: return 1; 7: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] reg_at(input int a);
        return regs_out[a*32 +: 32];
    endfunction

    function automatic logic [31:0] mask_n(input int n);
        return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    task automatic sbit(input logic b, output logic r);
        logic lo, hi;
        @(negedge clk);
        sclk = 1'b0;
        sdio_in = b;
        repeat (H - 1) @(negedge clk);
        lo = m_3w ? sdo : sdio_out;
        if (in_rd && (m_3w ? !(sdo_oe && !sdio_oe) : !(sdio_oe && !sdo_oe))) oe_bad++;
        @(negedge clk);
        sclk = 1'b1;
        repeat (H - 1) @(negedge clk);
        hi = m_3w ? sdo : sdio_out;
        if (in_rd && lo !== hi) glitch++;
        r = lo;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < 8; i++) begin
            int   p;
            logic r;
            p = m_lsb ? i : 7 - i;
            sbit(tx[p], r);
            rx[p] = r;
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input int n, input logic [31:0] v,
                          input logic [1:0] spare = 2'b00);
        logic       asc;
        logic [7:0] d;
        @(negedge clk) cs_n = 1'b0;
        xbyte({1'b0, spare, a}, d);
        asc = m_lsb;
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = asc ? k : n - 1 - k;
            xbyte(v[idx*8 +: 8], d);
            if (a == 5'd0 && idx == 0) begin
                m_lsb = v[0];
                m_3w  = v[1];
            end
        end
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [4:0] a, input int n, output logic [31:0] v);
        logic       asc;
        logic [7:0] d;
        v = '0;
        @(negedge clk) cs_n = 1'b0;
        xbyte({1'b1, 2'b00, a}, d);
        asc = m_lsb;
        in_rd = 1'b1;
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = asc ? k : n - 1 - k;
            xbyte(8'h00, d);
            v[idx*8 +: 8] = d;
        end
        in_rd = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic commit();
        @(negedge clk) update = 1'b1;
        repeat (4) @(negedge clk);
        update = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R12 sync_clk in reset", {31'd0, sync_clk}, 32'd0);
        @(negedge clk) rst = 1'b0;
        repeat (4) @(negedge clk);
        for (int a = 0; a < 8; a++) check("R12 regs_out after reset", reg_at(a), 32'd0);
        check("R9 oe idle after reset", {30'd0, sdio_oe, sdo_oe}, 32'd0);
    endtask

    task automatic t_counts();
        logic [31:0] v, r;
        for (int a = 1; a < 8; a++) begin
            v = 32'h9E37_79B9 ^ (32'h0101_0101 * a);
            wr_reg(5'(a), exp_n(a), v);
        end
        for (int a = 1; a < 8; a++) check("R6 held before commit", reg_at(a), 32'd0);
        rd_reg(5'd3, 4, r);
        check("R6 readback before commit", r, 32'd0);
        commit();
        for (int a = 1; a < 8; a++) begin
            v = (32'h9E37_79B9 ^ (32'h0101_0101 * a)) & mask_n(exp_n(a));
            check("R2 byte count per address", reg_at(a), v);
            rd_reg(5'(a), exp_n(a), r);
            check("R4 MSB-first readback", r, v);
        end
        check("R3 read bit stable over high phase", glitch, 0);
    endtask

    task automatic t_spare();
        wr_reg(5'd2, 2, 32'h0000_BEEF, 2'b11);
        commit();
        check("R1 spare instruction bits ignored", reg_at(2), 32'h0000_BEEF);
    endtask

    task automatic t_undef();
        logic [31:0] r, keep4;
        keep4 = reg_at(4);
        wr_reg(5'd20, 1, 32'h0000_00FF);
        wr_reg(5'd5, 2, 32'h0000_1357);
        commit();
        check("R11 undefined write has no effect", reg_at(4), keep4);
        check("R11 one byte then next cycle aligned", reg_at(5), 32'h0000_1357);
        rd_reg(5'd20, 1, r);
        check("R11 undefined read returns zero", r, 32'd0);
        rd_reg(5'd5, 2, r);
        check("R11 read after undefined aligned", r, 32'h0000_1357);
    endtask

    task automatic t_lsb();
        logic [31:0] r;
        wr_reg(5'd0, 4, 32'h0000_0001);
        wr_reg(5'd3, 4, 32'h1122_3344);
        commit();
        check("R4 LSB-first write", reg_at(3), 32'h1122_3344);
        rd_reg(5'd3, 4, r);
        check("R4 LSB-first readback", r, 32'h1122_3344);
        wr_reg(5'd0, 4, 32'h7352_C100);
        commit();
        check("R5 order change mid-transfer", reg_at(0), 32'h7352_C100);
        rd_reg(5'd0, 4, r);
        check("R5 MSB mode after change", r, 32'h7352_C100);
    endtask

    task automatic t_3wire();
        logic [31:0] r;
        oe_bad = 0;
        wr_reg(5'd0, 4, 32'h0000_0002);
        rd_reg(5'd2, 2, r);
        check("R10 separate pin read data", r, 32'h0000_BEEF);
        check("R10 separate pin enables", oe_bad, 0);
        wr_reg(5'd0, 4, 32'h0000_0000);
        rd_reg(5'd5, 2, r);
        check("R10 shared pin read data", r, 32'h0000_1357);
        check("R10 shared pin enables", oe_bad, 0);
    endtask

    task automatic t_csn();
        int bad;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) sclk = 1'b0; sdio_in = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            if (sdio_oe || sdo_oe) bad++;
        end
        check("R9 oe low while deselected", bad, 0);
        wr_reg(5'd6, 1, 32'h0000_005A);
        commit();
        check("R9 edges while deselected ignored", reg_at(6), 32'h0000_005A);
    endtask

    task automatic t_prst();
        logic [7:0] d;
        logic       r;
        @(negedge clk) cs_n = 1'b0;
        xbyte({3'b000, 5'd6}, d);
        for (int i = 0; i < 5; i++) sbit(1'b1, r);
        @(negedge clk) port_rst = 1'b1;
        repeat (2) @(negedge clk);
        port_rst = 1'b0;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_reg(5'd7, 4, 32'hDEAD_BEEF);
        commit();
        check("R8 aborted byte discarded", reg_at(6), 32'h0000_005A);
        check("R8 fresh instruction after abort", reg_at(7), 32'hDEAD_BEEF);
    endtask

    task automatic t_update();
        logic [31:0] keep1;
        logic [7:0]  s;
        int          bad;
        keep1 = reg_at(1);
        wr_reg(5'd1, 3, 32'h000F_0F0F);
        repeat (40) @(negedge clk);
        check("R6 no commit without update", reg_at(1), keep1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            s[i] = sync_clk;
        end
        bad = 0;
        for (int i = 0; i < 4; i++) if (s[i] !== s[i+4]) bad++;
        for (int i = 0; i < 6; i++) if (s[i] === s[i+2]) bad++;
        check("R7 sync_clk divide by 4", bad, 0);
        commit();
        check("R7 update commits buffers", reg_at(1), 32'h000F_0F0F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_counts();
        t_spare();
        t_undef();
        t_lsb();
        t_3wire();
        t_csn();
        t_prst();
        t_update();
        finish_run();
    end

endmodule